// File: doc/BRIEF.md
# Single-Wire Slave Slot and Reset Front End

This block is the time-slot front end of a slave on a single-wire, open-drain bus. It works on a synchronized copy of the line and a one-cycle pulse that arrives once per microsecond. Every bus event starts when the master pulls the idle-high line low. The block measures how long the line stays low. A low period of slot length becomes a received bit. A low period of reset length becomes a reset, and the block answers it with a presence pulse after a short gap. It keeps a speed flag that selects between standard and overdrive timing, and it reports when a long reset drops the speed back to standard.

The addressing layer above sees only bits. Before each slot it presents `tx_bit_i`, and the block latches that value on the falling edge. A latched 0 makes the block pull the line low for a hold time, which answers a read slot with 0. A latched 1 leaves the line released. Every completed slot reports the level that the line had at the sample point. The addressing layer pulses `od_set_i` to enter overdrive. Two digital stand-ins replace the analog input conditioning. The first is a one-tick falling-edge filter, which applies at standard speed only. The second is a rise-confirmation run of four consecutive high samples, which applies at both speeds.

Top module: `sw_slot_frontend`

## Requirements
- R1: After reset, `pull_o`, `rx_valid_o`, `reset_o`, `speed_drop_o` and `od_o` are all 0, so the block starts at standard speed.
- R2: At standard speed, a low that returns high before the first microsecond tick after the fall is ignored and produces no event. In overdrive the same short low starts a slot, and that slot reports bit 1.
- R3: The line counts as released only after 4 consecutive high samples. Shorter high runs during a rise belong to the same low period and do not start a new slot.
- R4: A slot reports the line level at the sample point, which is 30 ticks after the fall at standard speed and 3 ticks in overdrive (low = 0). `rx_valid_o` pulses for one cycle at whichever comes later: the clock after the sample tick, or the clock after the 4th confirming high sample.
- R5: `tx_bit_i` is latched at the fall. A latched 0 asserts `pull_o` from the next cycle for 28 ticks at standard speed or 2 ticks in overdrive. A latched 1 never asserts `pull_o`.
- R6: At standard speed, a low of more than 120 ticks produces a `reset_o` pulse, and the speed stays standard.
- R7: In overdrive, a low of more than 16 and at most 80 ticks produces a `reset_o` pulse. Overdrive is kept and `speed_drop_o` stays 0.
- R8: In overdrive, a low of more than 80 ticks (this includes 480 and longer) produces a `reset_o` pulse together with `speed_drop_o`, and `od_o` reads 0 in that same cycle.
- R9: After a reset, `pull_o` first stays 0 for a gap of 30 ticks (standard) or 3 ticks (overdrive). It then stays 1 for 120 or 12 ticks. The speed used is the one in force after the reset.
- R10: A pulse on `od_set_i` makes `od_o` read 1 from the next cycle.
- R11: At standard speed, a low of 100 ticks is a slot, not a reset. It reports bit 0 and no `reset_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronized bus level (1 = released) |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| tx_bit_i | input | 1 | Bit to answer in the next slot; latched at the falling edge |
| od_set_i | input | 1 | Pulse from the addressing layer that enters overdrive |
| pull_o | output | 1 | 1 = drive the bus low |
| rx_valid_o | output | 1 | One-cycle strobe: a slot completed |
| rx_bit_o | output | 1 | Bit of the completed slot |
| reset_o | output | 1 | One-cycle strobe: a reset was recognized |
| speed_drop_o | output | 1 | One-cycle strobe with `reset_o`: overdrive was left |
| od_o | output | 1 | Current speed flag (1 = overdrive) |

## Verification
Results fall into three timing cases. A slot whose sample point comes before the release delivers its bit on the fifth clock after the line goes high. A slot released before its sample point delivers on the clock after the sample tick. A reset strobe follows the release with the same five-clock delay. The bench drives the line on falling clock edges and pushes each predicted strobe into a queue, and a monitor sampling on falling edges pops and compares every strobe as it appears. One overdrive slot checks the five-clock latency cycle by cycle. Presence gap and length are counted in clocks and accepted within one tick. The ignored-glitch cases are checked by confirming that no strobe arrives within a window of 40 ticks.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_GAP  = 2'd2,
        ST_PRES = 2'd3
    } fe_state_e;

    // Timing set for one speed, all values in microsecond ticks.
    typedef struct packed {
        logic [31:0] sample;
        logic [31:0] hold;
        logic [31:0] gap;
        logic [31:0] pres;
        logic [31:0] filt;
    } speed_cfg_t;

endpackage

// File: rtl/sw_rise_filter.sv
module sw_rise_filter #(
    parameter int unsigned RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic high_ok_o
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        if (!line_i)
            run_d = '0;
        else if (run_q == RW'(RUN_LEN))
            run_d = run_q;
        else
            run_d = run_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign high_ok_o = (run_q == RW'(RUN_LEN));

    // R3
    rel_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_ok_o |-> $past(line_i));
    // R3
    low_breaks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_i |=> !high_ok_o);
endmodule

// File: rtl/sw_speed_cfg.sv
module sw_speed_cfg
    import sw_slot_pkg::*;
#(
    parameter int unsigned STD_SAMPLE_US = 30,
    parameter int unsigned OD_SAMPLE_US  = 3,
    parameter int unsigned STD_HOLD_US   = 28,
    parameter int unsigned OD_HOLD_US    = 2,
    parameter int unsigned STD_GAP_US    = 30,
    parameter int unsigned OD_GAP_US     = 3,
    parameter int unsigned STD_PRES_US   = 120,
    parameter int unsigned OD_PRES_US    = 12,
    parameter int unsigned FALL_FILT_US  = 1
) (
    input  logic       od_i,
    output speed_cfg_t cfg_o
);
    always_comb begin
        cfg_o.sample = od_i ? OD_SAMPLE_US : STD_SAMPLE_US;
        cfg_o.hold   = od_i ? OD_HOLD_US   : STD_HOLD_US;
        cfg_o.gap    = od_i ? OD_GAP_US    : STD_GAP_US;
        cfg_o.pres   = od_i ? OD_PRES_US   : STD_PRES_US;
        cfg_o.filt   = od_i ? 32'd0        : FALL_FILT_US;
    end
endmodule

// File: rtl/sw_reset_class.sv
module sw_reset_class #(
    parameter int unsigned CNT_W          = 10,
    parameter int unsigned STD_RST_US     = 120,
    parameter int unsigned OD_RST_US      = 16,
    parameter int unsigned OD_KEEP_MAX_US = 80
) (
    input  logic             od_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             is_reset_o,
    output logic             drop_o
);
    logic [31:0] len32;
    assign len32      = 32'(len_i);
    assign is_reset_o = od_i ? (len32 > OD_RST_US) : (len32 > STD_RST_US);
    assign drop_o     = od_i && (len32 > OD_KEEP_MAX_US);
endmodule

// File: rtl/sw_slot_frontend.sv
module sw_slot_frontend
    import sw_slot_pkg::*;
#(
    parameter int unsigned STD_SAMPLE_US  = 30,
    parameter int unsigned OD_SAMPLE_US   = 3,
    parameter int unsigned STD_HOLD_US    = 28,
    parameter int unsigned OD_HOLD_US     = 2,
    parameter int unsigned STD_RST_US     = 120,
    parameter int unsigned OD_RST_US      = 16,
    parameter int unsigned OD_KEEP_MAX_US = 80,
    parameter int unsigned STD_GAP_US     = 30,
    parameter int unsigned OD_GAP_US      = 3,
    parameter int unsigned STD_PRES_US    = 120,
    parameter int unsigned OD_PRES_US     = 12,
    parameter int unsigned FALL_FILT_US   = 1,
    parameter int unsigned RISE_RUN       = 4,
    parameter int unsigned CNT_W          = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic us_tick_i,
    input  logic tx_bit_i,
    input  logic od_set_i,
    output logic pull_o,
    output logic rx_valid_o,
    output logic rx_bit_o,
    output logic reset_o,
    output logic speed_drop_o,
    output logic od_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        fe_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             rel;
        logic             smp_done;
        logic             smp_bit;
        logic             tx_bit;
        logic             slot_od;
        logic             od;
        logic             rx_valid;
        logic             rx_bit;
        logic             rst_evt;
        logic             drop;
    } fe_regs_t;

    fe_regs_t         r_d, r_q;
    logic             high_ok;
    logic             cfg_od;
    speed_cfg_t       cfg;
    logic             is_rst, drop_req;
    logic [CNT_W-1:0] cnt_nx;

    sw_rise_filter #(.RUN_LEN(RISE_RUN)) rise_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .high_ok_o (high_ok)
    );

    // Slot timing follows the speed latched at the fall; everything else the live flag.
    assign cfg_od = (r_q.st == ST_SLOT) ? r_q.slot_od : r_q.od;

    sw_speed_cfg #(
        .STD_SAMPLE_US (STD_SAMPLE_US), .OD_SAMPLE_US (OD_SAMPLE_US),
        .STD_HOLD_US   (STD_HOLD_US),   .OD_HOLD_US   (OD_HOLD_US),
        .STD_GAP_US    (STD_GAP_US),    .OD_GAP_US    (OD_GAP_US),
        .STD_PRES_US   (STD_PRES_US),   .OD_PRES_US   (OD_PRES_US),
        .FALL_FILT_US  (FALL_FILT_US)
    ) cfg_i (
        .od_i  (cfg_od),
        .cfg_o (cfg)
    );

    sw_reset_class #(
        .CNT_W          (CNT_W),
        .STD_RST_US     (STD_RST_US),
        .OD_RST_US      (OD_RST_US),
        .OD_KEEP_MAX_US (OD_KEEP_MAX_US)
    ) class_i (
        .od_i       (r_q.slot_od),
        .len_i      (r_q.cnt),
        .is_reset_o (is_rst),
        .drop_o     (drop_req)
    );

    always_comb begin
        cnt_nx = r_q.cnt;
        if (us_tick_i && r_q.cnt != CNT_MAX)
            cnt_nx = r_q.cnt + CNT_W'(1);
    end

    always_comb begin
        r_d          = r_q;
        r_d.rx_valid = 1'b0;
        r_d.rst_evt  = 1'b0;
        r_d.drop     = 1'b0;
        if (od_set_i)
            r_d.od = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (!line_i) begin
                    r_d.st       = ST_SLOT;
                    r_d.cnt      = '0;
                    r_d.armed    = (cfg.filt == 32'd0);
                    r_d.rel      = 1'b0;
                    r_d.smp_done = 1'b0;
                    r_d.smp_bit  = 1'b0;
                    r_d.tx_bit   = tx_bit_i;
                    r_d.slot_od  = r_q.od;
                end
            end
            ST_SLOT: begin
                r_d.cnt = cnt_nx;
                if (us_tick_i && !r_q.armed && 32'(cnt_nx) >= cfg.filt)
                    r_d.armed = 1'b1;
                if (us_tick_i && !r_q.smp_done && 32'(cnt_nx) == cfg.sample) begin
                    r_d.smp_done = 1'b1;
                    r_d.smp_bit  = line_i;
                end
                if (!r_q.rel) begin
                    if (high_ok) begin
                        if (!r_q.armed) begin
                            r_d.st = ST_IDLE;
                        end else if (is_rst) begin
                            r_d.rst_evt = 1'b1;
                            r_d.drop    = drop_req;
                            if (drop_req)
                                r_d.od = 1'b0;
                            r_d.st  = ST_GAP;
                            r_d.cnt = '0;
                        end else if (r_q.smp_done) begin
                            r_d.rx_valid = 1'b1;
                            r_d.rx_bit   = r_q.smp_bit;
                            r_d.st       = ST_IDLE;
                        end else begin
                            r_d.rel = 1'b1;
                        end
                    end
                end else if (r_d.smp_done) begin
                    r_d.rx_valid = 1'b1;
                    r_d.rx_bit   = r_d.smp_bit;
                    r_d.st       = ST_IDLE;
                end
            end
            ST_GAP: begin
                r_d.cnt = cnt_nx;
                if (us_tick_i && 32'(cnt_nx) == cfg.gap) begin
                    r_d.st  = ST_PRES;
                    r_d.cnt = '0;
                end
            end
            ST_PRES: begin
                r_d.cnt = cnt_nx;
                if (us_tick_i && 32'(cnt_nx) == cfg.pres)
                    r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pull_o       = (r_q.st == ST_PRES) ||
                          ((r_q.st == ST_SLOT) && !r_q.tx_bit && (32'(r_q.cnt) < cfg.hold));
    assign rx_valid_o   = r_q.rx_valid;
    assign rx_bit_o     = r_q.rx_bit;
    assign reset_o      = r_q.rst_evt;
    assign speed_drop_o = r_q.drop;
    assign od_o         = r_q.od;

    // R8
    drop_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        speed_drop_o |-> (reset_o && !od_o));
    // R8
    drop_from_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        speed_drop_o |-> $past(od_o));
    // R7
    keep_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_o && !speed_drop_o) |-> (od_o == $past(od_o) || $past(od_set_i)));
    // R4
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid_o, reset_o}));
    // R9
    gap_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o |=> !pull_o);
endmodule

// File: tb/sw_slot_frontend_tb_top.sv
module sw_slot_frontend_tb_top;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic tx_bit = 1'b1;
    logic od_set = 1'b0;
    int   cyc = 0;
    logic tick;
    logic line;
    logic pull_o, rx_valid_o, rx_bit_o, reset_o, speed_drop_o, od_o;

    int n_chk = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        bit    is_rst;
        bit    val;
        bit    drop;
        bit    od;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tick = ((cyc % DIV) == DIV - 1);
    assign line = !(m_low || pull_o);

    sw_slot_frontend dut_i (
        .clk (clk), .rst_n (rst_n), .line_i (line), .us_tick_i (tick),
        .tx_bit_i (tx_bit), .od_set_i (od_set), .pull_o (pull_o),
        .rx_valid_o (rx_valid_o), .rx_bit_o (rx_bit_o), .reset_o (reset_o),
        .speed_drop_o (speed_drop_o), .od_o (od_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_rx(input bit v, input string req);
        exp_t e;
        e.is_rst = 1'b0; e.val = v; e.drop = 1'b0; e.od = 1'b0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_rst(input bit drop, input bit od, input string req);
        exp_t e;
        e.is_rst = 1'b1; e.val = 1'b0; e.drop = drop; e.od = od; e.req = req;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (rx_valid_o || reset_o)) begin
            evt_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3", "unexpected event (rx,rst)",
                    {30'd0, rx_valid_o, reset_o}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_rst) begin
                    chk(reset_o && !rx_valid_o, e.req, "reset strobe", int'(reset_o), 1);
                    chk(speed_drop_o == e.drop, e.req, "speed drop", int'(speed_drop_o), int'(e.drop));
                    chk(od_o == e.od, e.req, "speed flag", int'(od_o), int'(e.od));
                end else begin
                    chk(rx_valid_o && !reset_o, e.req, "rx strobe", int'(rx_valid_o), 1);
                    chk(rx_bit_o == e.val, e.req, "rx bit", int'(rx_bit_o), int'(e.val));
                end
            end
        end
    end

    task automatic wait_us(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic slot(input int low_us, input bit tx, input int rec_us);
        tx_bit = tx;
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        tx_bit = 1'b1;
        wait_us(rec_us);
    endtask

    task automatic align_tick;
        @(negedge clk);
        while ((cyc % DIV) != DIV - 1) @(negedge clk);
    endtask

    task automatic do_reset(input int len, input bit drop, input bit od_after,
                            input int gap, input int pres, input string req);
        int c;
        push_rst(drop, od_after, req);
        m_low = 1'b1;
        wait_us(len);
        m_low = 1'b0;
        c = 0;
        while (!pull_o && c < 5000) begin @(negedge clk); c++; end
        chk(c >= (gap - 1) * DIV && c <= (gap + 1) * DIV, "R9", "presence gap cycles", c, gap * DIV);
        c = 0;
        while (pull_o && c < 5000) begin @(negedge clk); c++; end
        chk(c >= (pres - 1) * DIV && c <= (pres + 1) * DIV, "R9", "presence length cycles", c, pres * DIV);
        wait_us(5);
    endtask

    task automatic set_od;
        @(negedge clk);
        od_set = 1'b1;
        @(negedge clk);
        chk(od_o == 1'b1, "R10", "od after set", int'(od_o), 1);
        od_set = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ev0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!pull_o && !rx_valid_o && !reset_o && !speed_drop_o, "R1", "outputs in reset",
            {28'd0, pull_o, rx_valid_o, reset_o, speed_drop_o}, 0);
        chk(od_o == 1'b0, "R1", "speed in reset", int'(od_o), 0);
        rst_n = 1'b1;
        wait_us(3);

        // R4 standard write slots
        push_rx(1'b1, "R4"); slot(6, 1'b1, 40);
        push_rx(1'b0, "R4"); slot(60, 1'b1, 10);
        // R11 long slot, not a reset
        push_rx(1'b0, "R11"); slot(100, 1'b1, 10);

        // R2 short low at standard speed is ignored
        ev0 = evt_cnt;
        align_tick; m_low = 1'b1; @(negedge clk); @(negedge clk); m_low = 1'b0;
        wait_us(40);
        chk(evt_cnt == ev0, "R2", "events after std glitch", evt_cnt - ev0, 0);

        // R5 standard read 0
        push_rx(1'b1, "R5");
        tx_bit = 1'b0; m_low = 1'b1; wait_us(2); m_low = 1'b0; tx_bit = 1'b1;
        wait_us(8);
        chk(pull_o == 1'b1, "R5", "pull during std read0", int'(pull_o), 1);
        wait_us(22);
        chk(pull_o == 1'b0, "R5", "pull after std hold", int'(pull_o), 0);
        wait_us(10);
        // R5 standard read 1
        push_rx(1'b1, "R5");
        tx_bit = 1'b1; m_low = 1'b1; wait_us(2); m_low = 1'b0;
        wait_us(8);
        chk(pull_o == 1'b0, "R5", "pull during std read1", int'(pull_o), 0);
        wait_us(35);

        // R6 standard resets
        do_reset(500, 1'b0, 1'b0, 30, 120, "R6");
        do_reset(130, 1'b0, 1'b0, 30, 120, "R6");

        // R10 enter overdrive
        set_od;
        wait_us(2);

        // R4 overdrive write 0 with latency check
        push_rx(1'b0, "R4");
        m_low = 1'b1; wait_us(8); m_low = 1'b0;
        repeat (4) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R4", "rx strobe early", int'(rx_valid_o), 0);
        @(negedge clk);
        chk(rx_valid_o == 1'b1, "R4", "rx strobe on 5th clock", int'(rx_valid_o), 1);
        wait_us(10);
        push_rx(1'b1, "R4"); slot(1, 1'b1, 10);

        // R5 overdrive read 0
        push_rx(1'b1, "R5");
        tx_bit = 1'b0; m_low = 1'b1; wait_us(1); m_low = 1'b0; tx_bit = 1'b1;
        chk(pull_o == 1'b1, "R5", "pull during od read0", int'(pull_o), 1);
        wait_us(3);
        chk(pull_o == 1'b0, "R5", "pull after od hold", int'(pull_o), 0);
        wait_us(10);

        // R3 rise glitches inside one low period
        push_rx(1'b0, "R3");
        m_low = 1'b1; wait_us(8); m_low = 1'b0;
        repeat (3) @(negedge clk); m_low = 1'b1;
        repeat (2) @(negedge clk); m_low = 1'b0;
        wait_us(10);
        push_rx(1'b0, "R3");
        m_low = 1'b1; wait_us(6); m_low = 1'b0;
        repeat (2) @(negedge clk); m_low = 1'b1;
        repeat (3) @(negedge clk); m_low = 1'b0;
        wait_us(10);

        // R2 the same short low starts a slot in overdrive
        push_rx(1'b1, "R2");
        align_tick; m_low = 1'b1; @(negedge clk); @(negedge clk); m_low = 1'b0;
        wait_us(10);

        // R7 overdrive resets that keep speed
        do_reset(50, 1'b0, 1'b1, 3, 12, "R7");
        do_reset(20, 1'b0, 1'b1, 3, 12, "R7");
        // R8 resets that drop speed
        do_reset(200, 1'b1, 1'b0, 30, 120, "R8");
        set_od;
        wait_us(2);
        do_reset(600, 1'b1, 1'b0, 30, 120, "R8");

        wait_us(10);
        chk(exp_q.size() == 0, "R4", "undelivered expected events", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule